// File: doc/BRIEF.md
# Four-Register Interleaving Store Sequencer

The block turns one structure-store command into a stream of element-sized memory write requests. It reads four vector registers from a local 32-entry register model. The first register is named by the command, and the other three follow it with modulo-32 wraparound. For each element index it writes that element of the first, second, third and fourth register in turn, then moves to the next index. Memory therefore ends up holding packed four-element structures, not four back-to-back vectors.

A command carries the first register number, a 2-bit element-size code, a wide flag, a base address and an addressing mode. The element-size code gives element widths of 8, 16, 32 or 64 bits. The wide flag selects a 128-bit vector when set and a 64-bit vector when clear. In the plain mode the base is returned unchanged. In the post-increment mode the base is advanced once all writes have been accepted. The step is either the value of a named step register, or the total byte count when the step-register index is 31. An element as wide as its vector is refused. The block flags it as undefined and issues no writes.

Writes leave on a valid/ready channel with an address, a 64-bit data field and a byte-enable mask. A start pulse launches a command. Busy covers the whole command, and a done pulse reports the outcome together with the resulting base.

Top module: `quad_interleave_store`

## Requirements
- R1: A legal command issues exactly 4×N writes, where N = V/E is the number of elements per register. V is 128 when `cmd_wide`=1 and 64 when it is 0. E is 8<<`cmd_esize`. Each write carries the element in `wr_data` bits [E-1:0] with zeros above, and `wr_be` has its low E/8 bits set and the rest clear.
- R2: The four source registers are F, F+1, F+2 and F+3 modulo 32, where F is `cmd_first_reg`; F=30 reads 30, 31, 0, 1.
- R3: Writes are element-major. Write k carries element k/4 (element e sits at bits [e·E+E-1 : e·E] of the register) of source register k mod 4.
- R4: Write k goes to address `cmd_base` + k·(E/8).
- R5: A command with `cmd_esize`=3 and `cmd_wide`=0 issues no write. Its done pulse comes on the first cycle after the start edge, with `undef`=1, `wb_en`=0 and `base_out` equal to `cmd_base`.
- R6: With `cmd_post`=0, the done pulse carries `wb_en`=0 and `base_out` = `cmd_base`.
- R7: With `cmd_post`=1 and `cmd_step_reg`≠31, the done pulse carries `wb_en`=1 and `base_out` = `cmd_base` + `cmd_step_val`.
- R8: With `cmd_post`=1 and `cmd_step_reg`=31, the done pulse carries `wb_en`=1 and `base_out` = `cmd_base` + 4·V/8.
- R9: While `wr_valid`=1 and `wr_ready`=0, the next cycle keeps `wr_valid` high with the same address, data and byte enables. The sequence advances only on an accepted write.
- R10: After reset, `busy`, `done`, `undef` and `wr_valid` are 0. `busy` is 1 from the cycle after an accepted start through the done cycle, then 0. For a legal command, `done` pulses for one cycle in the cycle right after the final write is accepted.
- R11: A start pulse while `busy`=1 is ignored; the running command's writes and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vrf_wr_en | input | 1 | Register-model write strobe |
| vrf_wr_idx | input | 5 | Register-model write index |
| vrf_wr_data | input | 128 | Register-model write value |
| cmd_start | input | 1 | Launch pulse, taken only when idle |
| cmd_first_reg | input | 5 | First source register |
| cmd_esize | input | 2 | Element-size code, width 8<<code bits |
| cmd_wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| cmd_base | input | 64 | Base address |
| cmd_post | input | 1 | 1: post-increment base |
| cmd_step_reg | input | 5 | Step register index, 31 selects the byte-count step |
| cmd_step_val | input | 64 | Value of the step register |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 64 | Element, right-aligned |
| wr_be | output | 8 | Byte enables, low bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | With done: command refused |
| wb_en | output | 1 | With done: base was updated |
| base_out | output | 64 | Resulting base, valid with done |

## Verification
The bench loads random register contents. It runs every legal size/width pair with first registers 30 and 31, which expose a missing modulo-32 wrap: that error would read registers 32 and 33 as 0 and 1 in the wrong place, or repeat register 31. It holds `wr_ready` low at random so that a sequencer advancing without acceptance would skip or duplicate elements, or change an address mid-request. It also targets the refused 64-in-64 encoding, where a faulty design would emit writes or update the base, and both post-increment sources, where picking the wrong one gives a base off by the step value or the byte count. A start pulse injected mid-command catches a design that relaunches while busy.

// File: rtl/qis_pkg.sv
package qis_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_FIN  = 2'd2
   } sq_state_e;

   // An element is legal only when strictly narrower than its vector.
   function automatic logic elem_fits(input logic [1:0] sz, input logic wide,
                                      input int unsigned vreg_w);
      int unsigned vw;
      vw = wide ? vreg_w : vreg_w / 2;
      return (32'd8 << sz) < vw;
   endfunction

endpackage

// File: rtl/qis_vrf.sv
module qis_vrf #(
   parameter  int unsigned NREG   = 32,
   parameter  int unsigned VREG_W = 128,
   localparam int unsigned IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [VREG_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [VREG_W-1:0] rdata
);

   initial begin
      assert ((1 << IDX_W) == NREG)
         else $error("qis_vrf: NREG must be a power of two");
   end

   logic [NREG-1:0][VREG_W-1:0] ent_flat;

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      logic [VREG_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (we && (waddr == IDX_W'(g)))
            ent_q <= wdata;
      end
      assign ent_flat[g] = ent_q;
   end

   assign rdata = ent_flat[raddr];

endmodule

// File: rtl/qis_elem_pick.sv
module qis_elem_pick #(
   parameter  int unsigned VREG_W     = 128,
   localparam int unsigned ELEM_MAX_W = VREG_W / 2,
   localparam int unsigned BE_W       = ELEM_MAX_W / 8,
   localparam int unsigned NSIZE      = $clog2(ELEM_MAX_W / 8) + 1,
   localparam int unsigned SZ_W       = $clog2(NSIZE),
   localparam int unsigned EIDX_W     = $clog2(VREG_W / 8)
) (
   input  logic [VREG_W-1:0]     vec,
   input  logic [EIDX_W-1:0]     eidx,
   input  logic [SZ_W-1:0]       sz,
   output logic [ELEM_MAX_W-1:0] data,
   output logic [BE_W-1:0]       be
);

   initial begin
      assert (VREG_W >= 32 && (1 << $clog2(VREG_W)) == VREG_W)
         else $error("qis_elem_pick: VREG_W must be a power of two of at least 32");
   end

   logic [NSIZE-1:0][ELEM_MAX_W-1:0] cand;
   logic [NSIZE-1:0][BE_W-1:0]       bec;

   // One lane extractor per element width.
   for (genvar s = 0; s < NSIZE; s++) begin : g_sz
      localparam int unsigned EW = 8 << s;
      localparam int unsigned NE = VREG_W / EW;
      localparam int unsigned LW = (NE > 1) ? $clog2(NE) : 1;
      logic [LW-1:0] li;
      logic [EW-1:0] lane;
      assign li   = eidx[LW-1:0];
      assign lane = vec[li*EW +: EW];
      assign cand[s] = ELEM_MAX_W'(lane);
      assign bec[s]  = BE_W'((1 << (EW / 8)) - 1);
   end

   assign data = cand[sz];
   assign be   = bec[sz];

   always_comb begin
      if (sz <= SZ_W'(NSIZE - 1))
         p_be_low_run_r1 : assert ((be & (be + 1'b1)) == '0);
   end

endmodule

// File: rtl/qis_seq.sv
module qis_seq
   import qis_pkg::*;
#(
   parameter  int unsigned NREG      = 32,
   parameter  int unsigned VREG_W    = 128,
   parameter  int unsigned ADDR_W    = 64,
   parameter  int unsigned NSTRUCT   = 4,
   parameter  int unsigned GPR_IDX_W = 5,
   localparam int unsigned IDX_W     = $clog2(NREG),
   localparam int unsigned SEL_W     = $clog2(NSTRUCT),
   localparam int unsigned MAX_NE    = VREG_W / 8,
   localparam int unsigned EIDX_W    = $clog2(MAX_NE),
   localparam int unsigned OFFS_W    = $clog2(NSTRUCT * MAX_NE) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IDX_W-1:0]     first_reg,
   input  logic [1:0]           esize,
   input  logic                 wide,
   input  logic [ADDR_W-1:0]    base,
   input  logic                 post,
   input  logic [GPR_IDX_W-1:0] step_reg,
   input  logic [ADDR_W-1:0]    step_val,
   input  logic                 mem_ready,
   output logic                 mem_valid,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [IDX_W-1:0]     rd_idx,
   output logic [EIDX_W-1:0]    eidx,
   output logic [1:0]           sz,
   output logic                 busy,
   output logic                 done,
   output logic                 undef,
   output logic                 wb_en,
   output logic [ADDR_W-1:0]    base_out
);

   initial begin
      assert (NSTRUCT >= 2 && (1 << SEL_W) == NSTRUCT)
         else $error("qis_seq: NSTRUCT must be a power of two of at least 2");
      assert (ADDR_W >= OFFS_W)
         else $error("qis_seq: ADDR_W too narrow for the byte offset");
   end

   sq_state_e           state_q;
   logic [IDX_W-1:0]    vreg_q;
   logic [1:0]          sz_q;
   logic                wide_q;
   logic [ADDR_W-1:0]   base_q;
   logic                post_q;
   logic                imm_q;
   logic [ADDR_W-1:0]   sval_q;
   logic                bad_q;
   logic [SEL_W-1:0]    sel_q;
   logic [EIDX_W-1:0]   eidx_q;
   logic [OFFS_W-1:0]   offs_q;

   logic                legal_in;
   logic [EIDX_W:0]     ne_cur;
   logic [OFFS_W-1:0]   ebytes;
   logic                accept;
   logic                last_sel;
   logic                last_beat;
   logic [ADDR_W-1:0]   step;

   assign legal_in  = elem_fits(esize, wide, VREG_W);
   assign ne_cur    = (EIDX_W+1)'(MAX_NE) >> ({2'b00, ~wide_q} + {1'b0, sz_q});
   assign ebytes    = OFFS_W'(1) << sz_q;
   assign accept    = (state_q == SQ_RUN) && mem_ready;
   assign last_sel  = (sel_q == SEL_W'(NSTRUCT - 1));
   assign last_beat = last_sel && (eidx_q == EIDX_W'(ne_cur - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         vreg_q  <= '0;
         sz_q    <= '0;
         wide_q  <= 1'b0;
         base_q  <= '0;
         post_q  <= 1'b0;
         imm_q   <= 1'b0;
         sval_q  <= '0;
         bad_q   <= 1'b0;
         sel_q   <= '0;
         eidx_q  <= '0;
         offs_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  vreg_q  <= first_reg;
                  sz_q    <= esize;
                  wide_q  <= wide;
                  base_q  <= base;
                  post_q  <= post;
                  imm_q   <= (step_reg == '1);
                  sval_q  <= step_val;
                  bad_q   <= !legal_in;
                  sel_q   <= '0;
                  eidx_q  <= '0;
                  offs_q  <= '0;
                  state_q <= legal_in ? SQ_RUN : SQ_FIN;
               end
            end
            SQ_RUN: begin
               if (accept) begin
                  offs_q <= offs_q + ebytes;
                  sel_q  <= sel_q + 1'b1;
                  if (last_sel)
                     eidx_q <= eidx_q + 1'b1;
                  if (last_beat)
                     state_q <= SQ_FIN;
               end
            end
            SQ_FIN:  state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mem_valid = (state_q == SQ_RUN);
   assign mem_addr  = base_q + ADDR_W'(offs_q);
   assign rd_idx    = vreg_q + IDX_W'(sel_q);
   assign eidx      = eidx_q;
   assign sz        = sz_q;
   assign busy      = (state_q != SQ_IDLE);
   assign done      = (state_q == SQ_FIN);
   assign undef     = done && bad_q;
   assign wb_en     = done && post_q && !bad_q;

   always_comb begin
      step     = imm_q ? ADDR_W'(offs_q) : sval_q;
      base_out = wb_en ? (base_q + step) : base_q;
   end

   p_refused_silent_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !legal_in) |=> (done && undef && !mem_valid));

   p_done_after_last_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !undef) |-> $past(mem_valid && mem_ready));

   p_valid_in_busy_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> busy);

   p_reg_rotate_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && $past(mem_valid && mem_ready)) |->
         ((rd_idx == IDX_W'($past(rd_idx) + 1'b1)) || (rd_idx == vreg_q)));

   p_start_ignored_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(base_q) && $stable(vreg_q));

endmodule

// File: rtl/quad_interleave_store.sv
module quad_interleave_store #(
   parameter  int unsigned NREG       = 32,
   parameter  int unsigned VREG_W     = 128,
   parameter  int unsigned ADDR_W     = 64,
   parameter  int unsigned NSTRUCT    = 4,
   parameter  int unsigned GPR_IDX_W  = 5,
   localparam int unsigned IDX_W      = $clog2(NREG),
   localparam int unsigned ELEM_MAX_W = VREG_W / 2,
   localparam int unsigned BE_W       = ELEM_MAX_W / 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vrf_wr_en,
   input  logic [IDX_W-1:0]      vrf_wr_idx,
   input  logic [VREG_W-1:0]     vrf_wr_data,
   input  logic                  cmd_start,
   input  logic [IDX_W-1:0]      cmd_first_reg,
   input  logic [1:0]            cmd_esize,
   input  logic                  cmd_wide,
   input  logic [ADDR_W-1:0]     cmd_base,
   input  logic                  cmd_post,
   input  logic [GPR_IDX_W-1:0]  cmd_step_reg,
   input  logic [ADDR_W-1:0]     cmd_step_val,
   output logic                  wr_valid,
   input  logic                  wr_ready,
   output logic [ADDR_W-1:0]     wr_addr,
   output logic [ELEM_MAX_W-1:0] wr_data,
   output logic [BE_W-1:0]       wr_be,
   output logic                  busy,
   output logic                  done,
   output logic                  undef,
   output logic                  wb_en,
   output logic [ADDR_W-1:0]     base_out
);

   localparam int unsigned EIDX_W = $clog2(VREG_W / 8);

   initial begin
      assert (ELEM_MAX_W == 64)
         else $error("quad_interleave_store: the 2-bit size code needs a 128-bit vector");
   end

   logic [IDX_W-1:0]  rd_idx;
   logic [VREG_W-1:0] rd_vec;
   logic [EIDX_W-1:0] eidx;
   logic [1:0]        sz;

   qis_vrf #(.NREG(NREG), .VREG_W(VREG_W)) vrf_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (vrf_wr_en),
      .waddr (vrf_wr_idx),
      .wdata (vrf_wr_data),
      .raddr (rd_idx),
      .rdata (rd_vec)
   );

   qis_seq #(
      .NREG(NREG), .VREG_W(VREG_W), .ADDR_W(ADDR_W),
      .NSTRUCT(NSTRUCT), .GPR_IDX_W(GPR_IDX_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_start),
      .first_reg (cmd_first_reg),
      .esize     (cmd_esize),
      .wide      (cmd_wide),
      .base      (cmd_base),
      .post      (cmd_post),
      .step_reg  (cmd_step_reg),
      .step_val  (cmd_step_val),
      .mem_ready (wr_ready),
      .mem_valid (wr_valid),
      .mem_addr  (wr_addr),
      .rd_idx    (rd_idx),
      .eidx      (eidx),
      .sz        (sz),
      .busy      (busy),
      .done      (done),
      .undef     (undef),
      .wb_en     (wb_en),
      .base_out  (base_out)
   );

   qis_elem_pick #(.VREG_W(VREG_W)) pick_i (
      .vec  (rd_vec),
      .eidx (eidx),
      .sz   (sz),
      .data (wr_data),
      .be   (wr_be)
   );

   p_hold_stall_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=>
         (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

   p_addr_step_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && $past(wr_valid && wr_ready)) |->
         (wr_addr == $past(wr_addr) + ADDR_W'($countones($past(wr_be)))));

   p_wb_with_done_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en || undef) |-> done);

endmodule

// File: tb/quad_interleave_store_tb.sv
module quad_interleave_store_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         vrf_wr_en;
   logic [4:0]   vrf_wr_idx;
   logic [127:0] vrf_wr_data;
   logic         cmd_start;
   logic [4:0]   cmd_first_reg;
   logic [1:0]   cmd_esize;
   logic         cmd_wide;
   logic [63:0]  cmd_base;
   logic         cmd_post;
   logic [4:0]   cmd_step_reg;
   logic [63:0]  cmd_step_val;
   logic         wr_valid;
   logic         wr_ready;
   logic [63:0]  wr_addr;
   logic [63:0]  wr_data;
   logic [7:0]   wr_be;
   logic         busy;
   logic         done;
   logic         undef;
   logic         wb_en;
   logic [63:0]  base_out;

   always #2 clk = ~clk;

   quad_interleave_store dut_i (
      .clk(clk), .rst_n(rst_n),
      .vrf_wr_en(vrf_wr_en), .vrf_wr_idx(vrf_wr_idx), .vrf_wr_data(vrf_wr_data),
      .cmd_start(cmd_start), .cmd_first_reg(cmd_first_reg), .cmd_esize(cmd_esize),
      .cmd_wide(cmd_wide), .cmd_base(cmd_base), .cmd_post(cmd_post),
      .cmd_step_reg(cmd_step_reg), .cmd_step_val(cmd_step_val),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .busy(busy), .done(done),
      .undef(undef), .wb_en(wb_en), .base_out(base_out)
   );

   int unsigned  n_run  = 0;
   int unsigned  n_fail = 0;
   bit           finished = 1'b0;
   bit [127:0]   model_rf [32];
   bit [63:0]    rec_addr [64];
   bit [63:0]    rec_data [64];
   bit [7:0]     rec_be   [64];
   int           rec_n;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit [63:0] exp_elem(input int r, input int e, input int eb);
      bit [127:0] sh;
      bit [63:0]  m;
      sh = model_rf[r] >> (e * 8 * eb);
      m  = (eb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * eb)) - 64'd1);
      return sh[63:0] & m;
   endfunction

   task automatic load_rf();
      for (int i = 0; i < 32; i++) begin
         bit [127:0] v;
         v = {$urandom(), $urandom(), $urandom(), $urandom()};
         @(negedge clk);
         vrf_wr_en   = 1'b1;
         vrf_wr_idx  = 5'(i);
         vrf_wr_data = v;
         model_rf[i] = v;
      end
      @(negedge clk);
      vrf_wr_en = 1'b0;
   endtask

   task automatic run_cmd(input bit [4:0] fr, input bit [1:0] sz, input bit q,
                          input bit [63:0] base, input bit post, input bit [4:0] sreg,
                          input bit [63:0] sval, input int rdy_pct, input bit poke);
      int         eb, ne, cyc, last_acc, done_cyc;
      bit         legal, seen_done, hold_pend, got_undef, got_wb;
      bit [63:0]  hold_a, hold_d, got_base, exp_base;
      eb    = 1 << sz;
      ne    = (q ? 16 : 8) / eb;
      legal = !(sz == 2'd3 && !q);
      rec_n = 0; last_acc = -1; done_cyc = -1; seen_done = 0; hold_pend = 0;
      hold_a = '0; hold_d = '0; got_undef = 0; got_wb = 0; got_base = '0;
      @(negedge clk);
      cmd_start = 1'b1; cmd_first_reg = fr; cmd_esize = sz; cmd_wide = q;
      cmd_base = base; cmd_post = post; cmd_step_reg = sreg; cmd_step_val = sval;
      @(negedge clk);
      cyc = 0;
      while (!seen_done && cyc < 3000) begin
         wr_ready = (($urandom() % 100) < rdy_pct);
         if (poke && cyc == 1) begin
            // R11: second launch while the first is running
            cmd_start = 1'b1; cmd_first_reg = fr + 5'd7; cmd_base = base ^ 64'hF00;
            cmd_esize = 2'd0; cmd_wide = 1'b1;
         end else begin
            cmd_start = 1'b0;
         end
         #1;
         if (cyc == 0) chk(busy === 1'b1, "R10", "busy after start", 64'(busy), 64'd1);
         if (wr_valid) begin
            if (hold_pend) begin
               chk(wr_addr == hold_a, "R9", "address held in stall", wr_addr, hold_a);
               chk(wr_data == hold_d, "R9", "data held in stall", wr_data, hold_d);
            end
            if (wr_ready) begin
               if (rec_n < 64) begin
                  rec_addr[rec_n] = wr_addr; rec_data[rec_n] = wr_data; rec_be[rec_n] = wr_be;
               end
               rec_n++; last_acc = cyc; hold_pend = 0;
            end else begin
               hold_pend = 1; hold_a = wr_addr; hold_d = wr_data;
            end
         end
         if (done) begin
            seen_done = 1; done_cyc = cyc;
            got_undef = undef; got_wb = wb_en; got_base = base_out;
         end
         @(negedge clk);
         cyc++;
      end
      wr_ready = 1'b0;
      cmd_start = 1'b0;
      chk(seen_done, "R10", "done reached", 64'(seen_done), 64'd1);
      #1;
      chk(busy === 1'b0 && done === 1'b0, "R10", "idle after done", 64'({busy, done}), 64'd0);
      if (!legal) begin
         chk(rec_n == 0, "R5", "writes on refused cmd", 64'(rec_n), 64'd0);
         chk(done_cyc == 0, "R5", "refused done cycle", 64'(done_cyc), 64'd0);
         chk(got_undef == 1'b1, "R5", "undef flag", 64'(got_undef), 64'd1);
         chk(got_wb == 1'b0, "R5", "no writeback", 64'(got_wb), 64'd0);
         chk(got_base == base, "R5", "base unchanged", got_base, base);
      end else begin
         chk(rec_n == 4 * ne, "R1", "write count", 64'(rec_n), 64'(4 * ne));
         chk(done_cyc == last_acc + 1, "R10", "done after last accept",
             64'(done_cyc), 64'(last_acc + 1));
         chk(got_undef == 1'b0, "R5", "undef on legal cmd", 64'(got_undef), 64'd0);
         for (int k = 0; k < rec_n && k < 4 * ne; k++) begin
            int r;
            bit [63:0] ea, ed;
            bit [7:0]  ebe;
            r   = (fr + (k % 4)) % 32;                     // R2 register wrap
            ed  = exp_elem(r, k / 4, eb);                  // R3 element-major order
            ea  = base + 64'(k * eb);                      // R4 running offset
            ebe = 8'((1 << eb) - 1);                       // R1 low byte lanes
            chk(rec_data[k] == ed, "R3", $sformatf("data of write %0d (reg %0d)", k, r),
                rec_data[k], ed);
            chk(rec_addr[k] == ea, "R4", $sformatf("address of write %0d", k), rec_addr[k], ea);
            chk(rec_be[k] == ebe, "R1", $sformatf("byte enables of write %0d", k),
                64'(rec_be[k]), 64'(ebe));
         end
         if (!post) begin
            chk(got_wb == 1'b0, "R6", "wb_en in plain mode", 64'(got_wb), 64'd0);
            chk(got_base == base, "R6", "base in plain mode", got_base, base);
         end else if (sreg != 5'd31) begin
            exp_base = base + sval;
            chk(got_wb == 1'b1, "R7", "wb_en register step", 64'(got_wb), 64'd1);
            chk(got_base == exp_base, "R7", "base register step", got_base, exp_base);
         end else begin
            exp_base = base + 64'(q ? 64 : 32);
            chk(got_wb == 1'b1, "R8", "wb_en byte-count step", 64'(got_wb), 64'd1);
            chk(got_base == exp_base, "R8", "base byte-count step", got_base, exp_base);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; vrf_wr_en = 1'b0; vrf_wr_idx = '0; vrf_wr_data = '0;
      cmd_start = 1'b0; cmd_first_reg = '0; cmd_esize = '0; cmd_wide = 1'b0;
      cmd_base = '0; cmd_post = 1'b0; cmd_step_reg = '0; cmd_step_val = '0;
      wr_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk({busy, done, undef, wr_valid} === 4'b0000, "R10", "reset state",
          64'({busy, done, undef, wr_valid}), 64'd0);
      load_rf();

      // every legal size/width pair, wrapping first registers
      for (int qq = 0; qq < 2; qq++) begin
         for (int s = 0; s < 4; s++) begin
            if (!(s == 3 && qq == 0)) begin
               run_cmd(5'd30, 2'(s), 1'(qq), 64'h1000_0000 + 64'(s * 256), 1'b0, 5'd0, 64'd0, 100, 1'b0);
               run_cmd(5'd31, 2'(s), 1'(qq), 64'h2000_0003, 1'b1, 5'd31, 64'd0, 40, 1'b0);
            end
         end
      end
      // refused encoding, plain and post-increment
      run_cmd(5'd4, 2'd3, 1'b0, 64'hABCD_0000, 1'b0, 5'd0, 64'd0, 100, 1'b0);
      run_cmd(5'd9, 2'd3, 1'b0, 64'hABCD_1000, 1'b1, 5'd31, 64'd0, 100, 1'b0);
      // register step, including a negative step
      run_cmd(5'd12, 2'd1, 1'b1, 64'h4000, 1'b1, 5'd3, 64'h0000_0000_0001_2340, 70, 1'b0);
      run_cmd(5'd29, 2'd2, 1'b0, 64'h8000, 1'b1, 5'd30, 64'hFFFF_FFFF_FFFF_FFF0, 50, 1'b0);
      // start pulse while busy
      run_cmd(5'd5, 2'd0, 1'b1, 64'h9000, 1'b1, 5'd31, 64'd0, 60, 1'b1);
      run_cmd(5'd30, 2'd3, 1'b1, 64'h9900, 1'b0, 5'd0, 64'd0, 25, 1'b1);

      // random mix
      for (int t = 0; t < 40; t++) begin
         bit [63:0] b, sv;
         if (t == 20) load_rf();
         b  = {$urandom(), $urandom()};
         sv = {$urandom(), $urandom()};
         run_cmd(5'($urandom()), 2'($urandom()), 1'($urandom()), b, 1'($urandom()),
                 (($urandom() % 3) == 0) ? 5'd31 : 5'($urandom() % 31), sv,
                 20 + int'($urandom() % 81), (t % 7) == 3);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule